// File: doc/BRIEF.md
# Quad-Channel DAC Serial Register Front End

This block is the digital input side of a four-channel, 12-bit digital-to-analog converter. A fast system clock samples the six slow interface pins: serial clock, active-low chip select, serial data, active-low load strobe, active-low clear and clear-select. Each pin passes through a two-flop synchronizer. After that the block finds edges on the synchronized levels.

Serial bits fill a 16-bit input shift register. A falling edge on the load strobe copies the 12-bit data field into one of four channel registers. The 2-bit address field at the head of the word selects which one. An active-low clear forces every channel register to zero or to midscale and leaves the shift register untouched. The four channel values leave the block on one flat bus, and each value drives one converter ladder.

The shift clock is chip select ORed with the serial clock. A chip-select rise while the serial clock is low therefore clocks in a bit of its own. A shift taken while the load strobe is low raises a one-cycle protocol-error pulse.

Top module: `quad_dac_serial_if`

## Requirements
- R1: A bit is shifted in on each rising edge of the internal shift clock (chip select OR serial clock). The first bit sent ends up in bit 15 of the word. The word layout, first bit to last, is: address bit 1, address bit 0, two ignored fill bits, then data bits 11 down to 0.
- R2: If chip select rises while the serial clock is low, the shift clock rises and the current serial data bit is shifted in.
- R3: While chip select is high, serial clock activity and serial data have no effect, and the shift register keeps its value.
- R4: On a falling edge of the load strobe, the 12-bit data field goes to the channel chosen by the address: 00 to channel 0 (`chan_o[11:0]`), 01 to channel 1, 10 to channel 2, 11 to channel 3. The other channels are unchanged. This happens whatever the level of chip select.
- R5: While clear is low, all four channels are held at 12'h800 if clear-select is high and at 12'h000 if it is low. Clear wins over a load edge that arrives in the same cycle.
- R6: Clear does not alter the shift register. After clear is released, the channels keep the clear value until the next load falling edge, and that edge loads the word that was in the shift register.
- R7: A shift taken while the load strobe is low produces a one-cycle high pulse on `proto_err`, and the shift register still updates. No pulse appears otherwise.
- R8: After reset, all channels read zero and `proto_err` is low. Any pin change reaches the outputs within three system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_pin | input | 1 | Serial clock pin |
| csn_pin | input | 1 | Chip select, active low |
| sdi_pin | input | 1 | Serial data in |
| ldn_pin | input | 1 | Load strobe, active low, acts on its falling edge |
| clrn_pin | input | 1 | Clear, active low, level sensitive |
| clrsel_pin | input | 1 | Clear target select: 1 gives midscale, 0 gives zero |
| chan_o | output | 48 | Channel registers; channel k occupies bits [12k+11:12k] |
| proto_err | output | 1 | One-cycle pulse when a shift occurs while the load strobe is low |

## Verification
Two pairs of functions can fall in the same cycle.

- **Clear and load.** The bench sends a load strobe while clear is held low. It checks that every channel stays at the clear value, both during the clear and after it is released. A later strobe must then deliver the word that was shifted in before the clear.
- **Shift and load-low.** The bench holds the load strobe low while clocking in a bit. It checks that one error pulse is counted and that the shifted bit still appears in the next loaded value.

// File: rtl/quad_dac_serial_if.sv
module quad_dac_serial_if #(
  parameter int DW   = 12,
  parameter int AW   = 2,
  parameter int SYNC = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sclk_pin,
  input  logic                     csn_pin,
  input  logic                     sdi_pin,
  input  logic                     ldn_pin,
  input  logic                     clrn_pin,
  input  logic                     clrsel_pin,
  output logic [(1<<AW)*DW-1:0]    chan_o,
  output logic                     proto_err
);
  localparam int NCH = 1 << AW;
  localparam int WW  = AW + 2 + DW;
  localparam logic [DW-1:0] MID = DW'(1) << (DW-1);
  localparam logic [5:0] IDLE = 6'b011010;

  logic [5:0] sync_q [SYNC];
  logic [5:0] pins_s;
  logic       sclk_s, csn_s, sdi_s, ldn_s, clrn_s, clrsel_s;
  logic       shclk_q, ldn_q;
  logic       shift_rise, ld_fall;
  logic [WW-1:0] shreg;
  logic [AW-1:0] addr;
  logic [DW-1:0] data;
  logic [DW-1:0] ch_q [NCH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC; i++) sync_q[i] <= IDLE;
    end else begin
      sync_q[0] <= {clrsel_pin, clrn_pin, ldn_pin, sdi_pin, csn_pin, sclk_pin};
      for (int i = 1; i < SYNC; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign pins_s   = sync_q[SYNC-1];
  assign sclk_s   = pins_s[0];
  assign csn_s    = pins_s[1];
  assign sdi_s    = pins_s[2];
  assign ldn_s    = pins_s[3];
  assign clrn_s   = pins_s[4];
  assign clrsel_s = pins_s[5];

  assign shift_rise = (csn_s | sclk_s) & ~shclk_q;
  assign ld_fall    = ~ldn_s & ldn_q;
  assign addr       = shreg[WW-1 -: AW];
  assign data       = shreg[DW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shclk_q   <= 1'b1;
      ldn_q     <= 1'b1;
      shreg     <= '0;
      proto_err <= 1'b0;
    end else begin
      shclk_q   <= csn_s | sclk_s;
      ldn_q     <= ldn_s;
      proto_err <= shift_rise & ~ldn_s;
      if (shift_rise) shreg <= {shreg[WW-2:0], sdi_s};
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n)                              ch_q[g] <= '0;
      else if (!clrn_s)                        ch_q[g] <= clrsel_s ? MID : '0;
      else if (ld_fall && addr == AW'(g))      ch_q[g] <= data;
    end
    assign chan_o[g*DW +: DW] = ch_q[g];
  end
endmodule

module quad_dac_serial_if_chk #(
  parameter int DW = 12,
  parameter int AW = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  csn_s,
  input logic                  shclk_q,
  input logic                  ldn_s,
  input logic                  clrn_s,
  input logic                  clrsel_s,
  input logic                  ld_fall,
  input logic [AW+2+DW-1:0]    shreg,
  input logic [(1<<AW)*DW-1:0] chan_o,
  input logic                  proto_err
);
  localparam int NCH = 1 << AW;
  localparam logic [DW-1:0] MID = DW'(1) << (DW-1);

  a_r3_hold_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
    (csn_s && shclk_q) |=> $stable(shreg));

  a_r5_clear_value: assert property (@(posedge clk) disable iff (!rst_n)
    !clrn_s |=> chan_o == ($past(clrsel_s) ? {NCH{MID}} : '0));

  a_r6_clear_keeps_shreg: assert property (@(posedge clk) disable iff (!rst_n)
    (!clrn_s && csn_s && shclk_q) |=> $stable(shreg));

  a_r7_err_needs_ld_low: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> $past(!ldn_s));

  a_r7_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> !proto_err);

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    a_r4_load_target: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_fall && clrn_s && shreg[AW+2+DW-1 -: AW] == AW'(g))
      |=> chan_o[g*DW +: DW] == $past(shreg[DW-1:0]));
    a_r4_others_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (clrn_s && !(ld_fall && shreg[AW+2+DW-1 -: AW] == AW'(g)))
      |=> $stable(chan_o[g*DW +: DW]));
  end
endmodule

bind quad_dac_serial_if quad_dac_serial_if_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .csn_s(csn_s), .shclk_q(shclk_q), .ldn_s(ldn_s),
  .clrn_s(clrn_s), .clrsel_s(clrsel_s), .ld_fall(ld_fall), .shreg(shreg),
  .chan_o(chan_o), .proto_err(proto_err)
);

// File: tb/quad_dac_serial_if_tb.sv
module quad_dac_serial_if_tb;
  logic clk = 0;
  logic rst_n = 0;
  logic sclk_pin = 0, csn_pin = 1, sdi_pin = 0, ldn_pin = 1, clrn_pin = 1, clrsel_pin = 0;
  logic [47:0] chan_o;
  logic proto_err;

  quad_dac_serial_if u_dut (
    .clk(clk), .rst_n(rst_n), .sclk_pin(sclk_pin), .csn_pin(csn_pin),
    .sdi_pin(sdi_pin), .ldn_pin(ldn_pin), .clrn_pin(clrn_pin),
    .clrsel_pin(clrsel_pin), .chan_o(chan_o), .proto_err(proto_err)
  );

  always #2.5 clk = ~clk;

  int n_cmp = 0, n_bad = 0, err_seen = 0, cyc = 0;
  logic [15:0] sh_m = '0;
  logic [11:0] ch_m [4] = '{default: '0};

  always @(posedge clk) begin
    if (rst_n && proto_err) err_seen++;
    cyc++;
    if (cyc == 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic step(); repeat (4) @(negedge clk); endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int k = 0; k < 4; k++) check(req, 32'(chan_o[k*12 +: 12]), 32'(ch_m[k]));
  endtask

  function automatic logic [11:0] clr_val(input logic sel);
    return sel ? 12'h800 : 12'h000;
  endfunction

  task automatic send_word(input logic [1:0] a, input logic [11:0] d);
    logic [15:0] w = {a, 2'b00, d};
    sclk_pin = 1; step();
    csn_pin = 0; step();
    for (int i = 15; i >= 0; i--) begin
      sclk_pin = 0; sdi_pin = w[i]; step();
      sclk_pin = 1; step();
      sh_m = {sh_m[14:0], w[i]};
    end
    csn_pin = 1; step();
    sclk_pin = 0; step();
  endtask

  task automatic strobe();
    ldn_pin = 0; step();
    if (clrn_pin) ch_m[sh_m[15:14]] = sh_m[11:0];
    ldn_pin = 1; step();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1; step();
    // R8 reset state
    check("R8", 32'(chan_o), 32'(0));
    check("R8", 32'(chan_o[47:32]), 32'(0));
    check("R8", 32'(proto_err), 32'(0));

    // R1 R4 each address
    send_word(2'b00, 12'h123); strobe(); check_all("R4");
    send_word(2'b01, 12'hA5C); strobe(); check_all("R4");
    send_word(2'b10, 12'hFFF); strobe(); check_all("R1");
    send_word(2'b11, 12'h001); strobe(); check_all("R1");

    // R3 cs high: sclk toggling ignored
    for (int i = 0; i < 6; i++) begin
      sdi_pin = i[0]; sclk_pin = 1; step(); sclk_pin = 0; step();
    end
    ch_m[3] = 12'h0AA;
    strobe();
    check("R3", 32'(chan_o[47:36]), 32'h001);

    // R2 spurious bit via chip select rise with sclk low
    begin
      logic [15:0] w = {2'b10, 2'b11, 12'h5E7};
      for (int i = 15; i >= 0; i--) begin
        csn_pin = 0; sdi_pin = w[i]; step();
        csn_pin = 1; step();
        sh_m = {sh_m[14:0], w[i]};
      end
      strobe();
      check("R2", 32'(chan_o[35:24]), 32'h5E7);
    end

    // R4 load independent of chip select
    send_word(2'b01, 12'h3C3);
    sclk_pin = 1; step(); csn_pin = 0; step();
    strobe();
    csn_pin = 1; step(); sclk_pin = 0; step();
    check_all("R4");

    // R5 R6 clear with load colliding
    send_word(2'b01, 12'h777);
    clrsel_pin = 1; clrn_pin = 0; step();
    for (int k = 0; k < 4; k++) ch_m[k] = clr_val(1'b1);
    check_all("R5");
    strobe();
    check_all("R5");
    clrn_pin = 1; step();
    check_all("R6");
    strobe();
    check("R6", 32'(chan_o[23:12]), 32'h777);
    clrsel_pin = 0; clrn_pin = 0; step();
    for (int k = 0; k < 4; k++) ch_m[k] = clr_val(1'b0);
    check_all("R5");
    clrn_pin = 1; step();

    // R7 shift while load low
    check("R7", 32'(err_seen), 32'(0));
    ldn_pin = 0; step();
    ch_m[sh_m[15:14]] = sh_m[11:0];
    sclk_pin = 1; step(); csn_pin = 0; step();
    sclk_pin = 0; sdi_pin = 1; step(); sclk_pin = 1; step();
    sh_m = {sh_m[14:0], 1'b1};
    csn_pin = 1; step(); sclk_pin = 0; step();
    check("R7", 32'(err_seen), 32'(1));
    ldn_pin = 1; step();
    strobe();
    check_all("R7");
    err_seen = 0;

    // random traffic
    void'($urandom(32'h1F2E3D4C));
    for (int it = 0; it < 60; it++) begin
      logic [1:0] a = 2'($urandom_range(0, 3));
      logic [11:0] d = 12'($urandom);
      send_word(a, d);
      if ($urandom_range(0, 7) == 0) begin
        clrsel_pin = 1'($urandom); clrn_pin = 0; step();
        for (int k = 0; k < 4; k++) ch_m[k] = clr_val(clrsel_pin);
        check_all("R5");
        clrn_pin = 1; step();
      end
      strobe();
      check_all("R4");
    end
    check("R7", 32'(err_seen), 32'(0));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule